// File: doc/BRIEF.md
# Three-wire serial register slave

This block terminates a three-wire serial link made of a chip-enable, a serial clock and a single data line. The data line is split into an input, an output and an output enable for the pad. The link's CE and SCLK arrive already synchronized to the fast system clock. The block works only on their detected edges, so each SCLK half period must last at least four system clocks.

A transfer opens with a command byte that names a read or a write, one of two register spaces and an address. The two spaces are a nine-register clock/calendar bank and a 31-byte scratch RAM. The block then moves one byte, or a burst of bytes, between the link and the register banks. It does this through single-cycle read and write strobes that carry an address and a space select. Read data is expected from the bank one system clock after the read strobe.

Clock-space writes go into the bank's staging buffer. When CE falls, a one-cycle commit pulse tells the bank to copy that buffer into its live registers. This pulse is only issued when the transfer is complete enough to allow it.

Top module: `serial_reg_slave`

## Requirements
- R1: When CE is seen low, the output enable is low on the next clock and stays low; dropping CE at any point ends the transfer.
- R2: The command byte is sampled on rising SCLK, bit 0 first. Bit 0 is 1 for read and 0 for write, bits 5..1 are the address, bit 6 is 1 for RAM and 0 for clock space, and bit 7 must be 1.
- R3: Read data bits are launched one clock after a falling SCLK edge is seen, bit 0 first. The first bit follows the falling edge right after the eighth command bit.
- R4: The output enable is low on the clock after every rising SCLK edge seen while CE is high.
- R5: A single write takes eight data bits, bit 0 first, and gives exactly one write strobe with address, space and data. Further SCLK cycles are ignored until CE falls.
- R6: A single read issues a read strobe for its address, and the byte is sent again on each further group of eight SCLK cycles while CE stays high.
- R7: Address 31 selects burst mode, which starts at address 0 and steps the address by one after each byte.
- R8: A one-cycle commit pulse follows the clock after CE is seen low. It is only issued if the transfer wrote a clock register and, in a clock burst, bytes for addresses 0 to 7 were all received.
- R9: A RAM burst write gives one write strobe for each completed byte, however many bytes are sent.
- R10: Clock locations 9 to 30 and RAM location 31 get no write or read strobe, and they read back as 0x00.
- R11: A clock burst read wraps from address 8 back to 0. A RAM burst read wraps from address 30 back to 0.
- R12: A command with bit 7 clear, or a byte cut short by CE falling, gives no write strobe and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Synchronized chip enable |
| sclk_i | input | 1 | Synchronized serial clock |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial data to the pad |
| sdio_oe_o | output | 1 | Pad output enable |
| reg_rd_o | output | 1 | Read strobe to the register banks |
| reg_wr_o | output | 1 | Write strobe to the register banks |
| reg_addr_o | output | ADDR_W | Register address for the strobes |
| reg_ram_o | output | 1 | Space select: 1 RAM, 0 clock/calendar |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid one clock after the read strobe |
| commit_o | output | 1 | Commit pulse for staged clock writes |

## Verification
Every result is due a fixed number of clocks after the edge that causes it. The output enable drops one clock after a rising SCLK or a low CE is seen. A data bit is valid two clocks after the falling SCLK is applied. The write and read strobes come one clock after the rising edge that completes a byte, and the commit pulse comes one clock after CE is seen low. The bench changes inputs on falling clock edges. It holds each SCLK phase for four clocks and samples the data line just before the next rising SCLK, after every due cycle has passed. A per-clock monitor checks the output enable on the exact clock after each rising SCLK or low CE.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_WR,
      ST_RD,
      ST_HOLD
   } srs_state_e;

   // true when a location of the selected space holds data
   function automatic logic has_storage(input logic ram, input int unsigned addr,
                                        input int unsigned clk_regs,
                                        input int unsigned ram_bytes);
      return ram ? (addr < ram_bytes) : (addr < clk_regs);
   endfunction

   // burst step with wrap after the last stored location
   function automatic int unsigned step_addr(input logic ram, input int unsigned addr,
                                             input int unsigned clk_regs,
                                             input int unsigned ram_bytes);
      int unsigned last;
      last = ram ? (ram_bytes - 1) : (clk_regs - 1);
      return (addr >= last) ? 0 : addr + 1;
   endfunction

endpackage

// File: rtl/srs_edge.sv
module srs_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   initial assert (N >= 1) else $error("srs_edge: N must be at least 1");

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= 1'b0;
         else        last_q <= sig_i[g];
      end
      assign rise_o[g] = sig_i[g] & ~last_q;
      assign fall_o[g] = ~sig_i[g] & last_q;
   end

endmodule

// File: rtl/srs_rx_shift.sv
module srs_rx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  logic         din_i,
   output logic [W-1:0] word_o,
   output logic         done_o
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;

   initial assert (W == (1 << CW)) else $error("srs_rx_shift: W must be a power of two");

   logic [W-1:0]  acc_q;
   logic [CW-1:0] cnt_q;

   // word including the bit arriving now, LSB first
   always_comb begin
      word_o        = acc_q;
      word_o[cnt_q] = din_i;
   end

   assign done_o = shift_i && (cnt_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (shift_i) begin
         acc_q <= word_o;
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/srs_tx_shift.sv
module srs_tx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         launch_i,
   input  logic         retire_i,
   output logic         sdo_o,
   output logic         oe_o,
   output logic         wrap_o
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;

   initial assert (W == (1 << CW)) else $error("srs_tx_shift: W must be a power of two");

   logic [W-1:0]  hold_q;
   logic [CW-1:0] idx_q;

   assign wrap_o = retire_i && (idx_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         idx_q  <= '0;
         sdo_o  <= 1'b0;
         oe_o   <= 1'b0;
      end else if (clr_i) begin
         idx_q  <= '0;
         sdo_o  <= 1'b0;
         oe_o   <= 1'b0;
      end else begin
         if (load_i) hold_q <= data_i;
         if (launch_i) begin
            sdo_o <= hold_q[idx_q];
            oe_o  <= 1'b1;
         end
         if (retire_i) begin
            oe_o  <= 1'b0;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
   import srs_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 5,
   parameter int CLK_REGS      = 9,
   parameter int RAM_BYTES     = 31,
   parameter int CLK_BURST_MIN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              sclk_i,
   input  logic              sdio_i,
   output logic              sdio_o,
   output logic              sdio_oe_o,
   output logic              reg_rd_o,
   output logic              reg_wr_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_ram_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   output logic              commit_o
);

   localparam int          CMD_W      = ADDR_W + 3;
   localparam int          BURST_CODE = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] BURST_A = ADDR_W'(BURST_CODE);
   localparam logic [ADDR_W-1:0] FULL_A  = ADDR_W'(CLK_BURST_MIN - 1);

   initial begin
      assert (CMD_W == DATA_W) else $error("command layout needs DATA_W == ADDR_W + 3");
      assert (CLK_REGS >= 1 && CLK_REGS < BURST_CODE) else $error("CLK_REGS out of range");
      assert (RAM_BYTES >= 1 && RAM_BYTES <= BURST_CODE) else $error("RAM_BYTES out of range");
      assert (CLK_BURST_MIN >= 1 && CLK_BURST_MIN <= CLK_REGS) else $error("CLK_BURST_MIN out of range");
   end

   // ---------------- edges ----------------
   logic [1:0] rise, fall;
   logic sclk_rise, sclk_fall, ce_rise, ce_fall;

   srs_edge #(.N(2)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i ({ce_i, sclk_i}),
      .rise_o(rise),
      .fall_o(fall)
   );

   assign sclk_rise = rise[0];
   assign sclk_fall = fall[0];
   assign ce_rise   = rise[1];
   assign ce_fall   = fall[1];

   // ---------------- state ----------------
   srs_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ram_q;
   logic              burst_q;
   logic              clk_wr_q;
   logic              clk_full_q;
   logic              st1_go_q, st1_live_q;
   logic              ld_go_q, ld_live_q;

   logic active;
   assign active = ce_i && !ce_rise;

   // ---------------- receive ----------------
   logic              rx_shift, rx_clr, rx_done;
   logic [DATA_W-1:0] rx_word;

   assign rx_shift = active && sclk_rise && (state_q == ST_CMD || state_q == ST_WR);
   assign rx_clr   = ce_rise || ce_fall;

   srs_rx_shift #(.W(DATA_W)) i_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (rx_clr),
      .shift_i(rx_shift),
      .din_i  (sdio_i),
      .word_o (rx_word),
      .done_o (rx_done)
   );

   // command fields
   logic              cmd_rd, cmd_ram, cmd_ok, cmd_burst;
   logic [ADDR_W-1:0] cmd_addr, cmd_start;

   assign cmd_rd    = rx_word[0];
   assign cmd_addr  = rx_word[ADDR_W:1];
   assign cmd_ram   = rx_word[ADDR_W+1];
   assign cmd_ok    = rx_word[CMD_W-1];
   assign cmd_burst = (cmd_addr == BURST_A);
   assign cmd_start = cmd_burst ? '0 : cmd_addr;

   // ---------------- transmit ----------------
   logic              tx_launch, tx_retire, tx_wrap, tx_clr;
   logic [DATA_W-1:0] tx_data;

   assign tx_launch = active && sclk_fall && (state_q == ST_RD);
   assign tx_retire = active && sclk_rise && (state_q == ST_RD);
   assign tx_clr    = ce_rise || ce_fall;
   assign tx_data   = ld_live_q ? reg_rdata_i : '0;

   srs_tx_shift #(.W(DATA_W)) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tx_clr),
      .load_i  (ld_go_q),
      .data_i  (tx_data),
      .launch_i(tx_launch),
      .retire_i(tx_retire),
      .sdo_o   (sdio_o),
      .oe_o    (sdio_oe_o),
      .wrap_o  (tx_wrap)
   );

   // ---------------- fetch selection ----------------
   logic              fetch_go, fetch_ram, fetch_live;
   logic [ADDR_W-1:0] fetch_addr, addr_step;

   assign addr_step = ADDR_W'(step_addr(ram_q, 32'(addr_q), CLK_REGS, RAM_BYTES));

   always_comb begin
      fetch_go   = 1'b0;
      fetch_ram  = ram_q;
      fetch_addr = addr_q;
      if (active && state_q == ST_CMD && rx_done && cmd_ok && cmd_rd) begin
         fetch_go   = 1'b1;
         fetch_ram  = cmd_ram;
         fetch_addr = cmd_start;
      end else if (tx_wrap) begin
         fetch_go   = 1'b1;
         fetch_addr = burst_q ? addr_step : addr_q;
      end
   end

   assign fetch_live = has_storage(fetch_ram, 32'(fetch_addr), CLK_REGS, RAM_BYTES);

   logic wr_live;
   assign wr_live = has_storage(ram_q, 32'(addr_q), CLK_REGS, RAM_BYTES);

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         ram_q       <= 1'b0;
         burst_q     <= 1'b0;
         clk_wr_q    <= 1'b0;
         clk_full_q  <= 1'b0;
         st1_go_q    <= 1'b0;
         st1_live_q  <= 1'b0;
         ld_go_q     <= 1'b0;
         ld_live_q   <= 1'b0;
         reg_rd_o    <= 1'b0;
         reg_wr_o    <= 1'b0;
         reg_addr_o  <= '0;
         reg_ram_o   <= 1'b0;
         reg_wdata_o <= '0;
         commit_o    <= 1'b0;
      end else begin
         reg_rd_o  <= 1'b0;
         reg_wr_o  <= 1'b0;
         commit_o  <= 1'b0;
         st1_go_q  <= 1'b0;
         ld_go_q   <= st1_go_q;
         ld_live_q <= st1_live_q;
         if (ce_fall) begin
            state_q    <= ST_IDLE;
            commit_o   <= clk_wr_q && (!burst_q || clk_full_q);
            clk_wr_q   <= 1'b0;
            clk_full_q <= 1'b0;
            ld_go_q    <= 1'b0;
         end else if (ce_rise) begin
            state_q    <= ST_CMD;
            burst_q    <= 1'b0;
            clk_wr_q   <= 1'b0;
            clk_full_q <= 1'b0;
         end else if (ce_i) begin
            if (fetch_go) begin
               reg_rd_o   <= fetch_live;
               reg_addr_o <= fetch_addr;
               reg_ram_o  <= fetch_ram;
               st1_go_q   <= 1'b1;
               st1_live_q <= fetch_live;
               addr_q     <= fetch_addr;
            end
            case (state_q)
               ST_CMD: if (rx_done) begin
                  if (!cmd_ok) begin
                     state_q <= ST_HOLD;
                  end else begin
                     addr_q  <= cmd_start;
                     ram_q   <= cmd_ram;
                     burst_q <= cmd_burst;
                     state_q <= cmd_rd ? ST_RD : ST_WR;
                  end
               end
               ST_WR: if (rx_done) begin
                  if (wr_live) begin
                     reg_wr_o    <= 1'b1;
                     reg_addr_o  <= addr_q;
                     reg_ram_o   <= ram_q;
                     reg_wdata_o <= rx_word;
                     if (!ram_q) clk_wr_q <= 1'b1;
                  end
                  if (burst_q && !ram_q && addr_q == FULL_A) clk_full_q <= 1'b1;
                  if (burst_q) addr_q  <= addr_step;
                  else         state_q <= ST_HOLD;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/srs_checks.sv
module srs_checks #(
   parameter int ADDR_W    = 5,
   parameter int CLK_REGS  = 9,
   parameter int RAM_BYTES = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_i,
   input logic              sclk_i,
   input logic              sdio_oe_o,
   input logic              reg_rd_o,
   input logic              reg_wr_o,
   input logic [ADDR_W-1:0] reg_addr_o,
   input logic              reg_ram_o,
   input logic              commit_o
);

   // R1: pad released once CE is low
   p_oe_off_ce_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_i |=> !sdio_oe_o);

   // R4: pad released after each rising SCLK
   p_oe_off_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && sclk_i && !$past(sclk_i)) |=> !sdio_oe_o);

   // R3: driving starts only after a falling SCLK
   p_launch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdio_oe_o) |-> ($past(sclk_i, 2) && !$past(sclk_i)));

   // R8: commit follows a CE fall
   p_commit_ce_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (!$past(ce_i) && $past(ce_i, 2)));

   // R10: no strobe into a location without storage
   p_no_dead_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o || reg_rd_o) |->
         (reg_ram_o ? (32'(reg_addr_o) < RAM_BYTES) : (32'(reg_addr_o) < CLK_REGS)));

   // R5: strobes never overlap
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_rd_o, reg_wr_o, commit_o}));

   // R12: writes only inside an open transfer
   p_write_in_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> $past(ce_i));

endmodule

bind serial_reg_slave srs_checks #(
   .ADDR_W   (ADDR_W),
   .CLK_REGS (CLK_REGS),
   .RAM_BYTES(RAM_BYTES)
) i_srs_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_i      (ce_i),
   .sclk_i    (sclk_i),
   .sdio_oe_o (sdio_oe_o),
   .reg_rd_o  (reg_rd_o),
   .reg_wr_o  (reg_wr_o),
   .reg_addr_o(reg_addr_o),
   .reg_ram_o (reg_ram_o),
   .commit_o  (commit_o)
);

// File: tb/test_serial_reg_slave.sv
`timescale 1ns/1ps
module test_serial_reg_slave;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo, oe, rd, wr, ram, commit;
   logic [4:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata = 8'h00;

   always #5 clk = ~clk;

   serial_reg_slave i_serial_reg_slave (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdio_i(sdi),
      .sdio_o(sdo), .sdio_oe_o(oe), .reg_rd_o(rd), .reg_wr_o(wr),
      .reg_addr_o(addr), .reg_ram_o(ram), .reg_wdata_o(wdata),
      .reg_rdata_i(rdata), .commit_o(commit)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // bench register bank: staged clock writes, live clock regs, RAM
   logic [7:0] bank_ram [31];
   logic [7:0] bank_stage [9];
   logic [7:0] bank_clk [9];
   int wr_cnt = 0, commit_cnt = 0;

   initial begin
      for (int i = 0; i < 31; i++) bank_ram[i] = 8'h00;
      for (int i = 0; i < 9; i++) begin bank_stage[i] = 8'h00; bank_clk[i] = 8'h00; end
   end

   always @(posedge clk) begin
      if (wr) begin
         wr_cnt <= wr_cnt + 1;
         if (ram && addr < 31) bank_ram[addr] <= wdata;
         if (!ram && addr < 9) bank_stage[addr] <= wdata;
      end
      if (commit) begin
         commit_cnt <= commit_cnt + 1;
         for (int i = 0; i < 9; i++) bank_clk[i] <= bank_stage[i];
      end
      if (rd) rdata <= ram ? ((addr < 31) ? bank_ram[addr] : 8'hxx)
                           : ((addr < 9) ? bank_clk[addr] : 8'hxx);
   end

   // reference for the pad enable, checked on every clock
   logic smp_ce = 1'b0, smp_sclk = 1'b0, smp_sclk_d = 1'b0;
   always @(posedge clk) begin
      smp_sclk_d <= smp_sclk;
      smp_sclk   <= sclk;
      smp_ce     <= ce;
   end
   always @(negedge clk) begin
      if (rst_n) begin
         if (!smp_ce) chk("R1 oe after CE low", oe, 0);
         else if (smp_sclk && !smp_sclk_d) chk("R4 oe after SCLK rise", oe, 0);
      end
   end

   // expected contents, from the requirements
   logic [7:0] exp_ram [31];
   logic [7:0] exp_clk [9];
   logic [7:0] rbuf [40];

   function automatic logic [7:0] mk(input logic sp_ram, input logic [4:0] a, input logic is_rd);
      return {1'b1, sp_ram, a, is_rd};
   endfunction

   task automatic clk_bit(input logic b, output logic r, output logic oe_s);
      sdi = b;
      repeat (4) @(negedge clk);
      r = sdo;
      oe_s = oe;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic start();
      ce = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic stop();
      ce = 1'b0;
      sdi = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] v);
      logic r, o;
      for (int i = 0; i < 8; i++) clk_bit(v[i], r, o);
   endtask

   task automatic get_byte(output logic [7:0] v, output logic all_oe);
      logic r, o;
      all_oe = 1'b1;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b0, r, o);
         v[i] = r;
         all_oe &= o;
      end
   endtask

   task automatic do_write(input logic [7:0] cmd, input int n, input logic [7:0] base);
      start();
      put_byte(cmd);
      for (int k = 0; k < n; k++) put_byte(base + 8'(k));
      stop();
   endtask

   task automatic do_read(input logic [7:0] cmd, input int n);
      logic o;
      start();
      put_byte(cmd);
      for (int k = 0; k < n; k++) begin
         get_byte(rbuf[k], o);
         chk("R3 oe while sending", o, 1);
      end
      stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int w0, c0;
      logic r, o;
      for (int i = 0; i < 31; i++) exp_ram[i] = 8'h00;
      for (int i = 0; i < 9; i++) exp_clk[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // reset state (R1)
      chk("R1 reset oe", oe, 0);
      chk("R1 reset strobes", {rd, wr, commit}, 0);

      // R5: single RAM write, second byte ignored
      w0 = wr_cnt; c0 = commit_cnt;
      do_write(mk(1, 5'd5, 0), 2, 8'hA5);
      exp_ram[5] = 8'hA5;
      chk("R5 single write strobes", wr_cnt - w0, 1);
      chk("R5 single write data", bank_ram[5], 8'hA5);
      chk("R8 no commit for RAM", commit_cnt - c0, 0);

      // R2 R6: single read repeats the byte
      do_read(mk(1, 5'd5, 1), 2);
      chk("R2 R6 read byte", rbuf[0], exp_ram[5]);
      chk("R6 retransmit", rbuf[1], exp_ram[5]);

      // R8: single clock write commits
      c0 = commit_cnt;
      do_write(mk(0, 5'd2, 0), 1, 8'h59);
      exp_clk[2] = 8'h59;
      chk("R8 single clock commit", commit_cnt - c0, 1);
      do_read(mk(0, 5'd2, 1), 1);
      chk("R8 clock readback", rbuf[0], 8'h59);

      // R7 R9: short RAM burst
      w0 = wr_cnt;
      do_write(mk(1, 5'd31, 0), 3, 8'h11);
      for (int i = 0; i < 3; i++) exp_ram[i] = 8'h11 + 8'(i);
      chk("R9 burst strobes", wr_cnt - w0, 3);
      chk("R7 burst addr0", bank_ram[0], 8'h11);
      chk("R7 burst addr2", bank_ram[2], 8'h13);
      chk("R9 burst addr3 untouched", bank_ram[3], 8'h00);

      // R8: incomplete clock burst gives no commit
      c0 = commit_cnt;
      do_write(mk(0, 5'd31, 0), 5, 8'h40);
      chk("R8 short clock burst", commit_cnt - c0, 0);
      do_read(mk(0, 5'd0, 1), 1);
      chk("R8 clock reg unchanged", rbuf[0], exp_clk[0]);

      // R8: full clock burst commits
      c0 = commit_cnt;
      do_write(mk(0, 5'd31, 0), 8, 8'h20);
      for (int i = 0; i < 8; i++) exp_clk[i] = 8'h20 + 8'(i);
      chk("R8 full clock burst", commit_cnt - c0, 1);
      do_write(mk(0, 5'd8, 0), 1, 8'h77);
      exp_clk[8] = 8'h77;

      // R11: clock burst read wraps after 8
      do_read(mk(0, 5'd31, 1), 10);
      for (int k = 0; k < 10; k++) chk("R11 clock burst read", rbuf[k], exp_clk[k % 9]);

      // R11: RAM burst read wraps after 30
      do_read(mk(1, 5'd31, 1), 32);
      for (int k = 0; k < 32; k++) chk("R11 RAM burst read", rbuf[k], exp_ram[k % 31]);

      // R10: unused clock location
      w0 = wr_cnt; c0 = commit_cnt;
      do_write(mk(0, 5'd12, 0), 1, 8'h99);
      chk("R10 no strobe unused", wr_cnt - w0, 0);
      chk("R10 no commit unused", commit_cnt - c0, 0);
      do_read(mk(0, 5'd12, 1), 1);
      chk("R10 unused reads zero", rbuf[0], 8'h00);

      // R12: bit 7 clear
      w0 = wr_cnt;
      do_write(mk(1, 5'd7, 0) & 8'h7F, 1, 8'hEE);
      chk("R12 malformed no strobe", wr_cnt - w0, 0);
      do_read(mk(1, 5'd7, 1), 1);
      chk("R12 malformed ram kept", rbuf[0], exp_ram[7]);

      // R12: byte cut by CE
      w0 = wr_cnt; c0 = commit_cnt;
      start();
      put_byte(mk(1, 5'd9, 0));
      for (int i = 0; i < 5; i++) clk_bit(1'b1, r, o);
      stop();
      chk("R12 partial no strobe", wr_cnt - w0, 0);
      chk("R12 partial no commit", commit_cnt - c0, 0);

      // R1: CE dropped during a read
      start();
      put_byte(mk(1, 5'd5, 1));
      for (int i = 0; i < 3; i++) clk_bit(1'b0, r, o);
      ce = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 oe after abort", oe, 0);
      repeat (4) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule